// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block caches virtual-to-physical page translations for 4 KB pages. A 32-bit virtual address is split into a page offset (bits 11..0), a set selector (bits 16..12) and a 15-bit tag (bits 31..17). The buffer holds 128 translations organised as 32 sets of 4 ways. A lookup compares all four ways of the selected set at once. In the same cycle it returns a hit flag, a miss flag, a protection-fault flag and the 30-bit physical address. The physical address is the stored 18-bit page number followed by the untouched offset.

Each stored translation carries a valid flag, a written ("dirty") flag, a used ("reference") flag and a write-permission flag. A successful lookup marks its translation as used. A successful write marks it dirty. A write to a translation without permission is flagged as a fault and changes nothing. A refill port installs a new translation into the least recently used way of its set. When that way held a valid dirty translation, the displaced translation is reported on an eviction output for one cycle, so that the page table can be brought up to date. A single-cycle invalidate input empties the whole buffer.

Top module: `xlat_buf`

## Requirements
- R1: On a hit, `lk_paddr` equals the matching translation's 18-bit page number in bits 29..12, with `lk_vaddr[11:0]` in bits 11..0. On a miss, `lk_paddr` is zero. The set is `lk_vaddr[16:12]` and the tag is `lk_vaddr[31:17]`.
- R2: In the same cycle as a request, `lk_hit` is 1 exactly when a valid way of the selected set holds the tag, and `lk_miss` is its complement. While `lk_valid` is 0, `lk_hit`, `lk_miss` and `lk_fault` are all 0.
- R3: A write request (`lk_write`=1) that hits a translation whose write-permission flag is 0 raises `lk_fault` in the same cycle. It leaves that translation clean and leaves its set's recency order unchanged.
- R4: A permitted write hit sets the translation's dirty flag. Any non-faulting hit sets its reference flag.
- R5: A refill (`fill_valid`=1) installs a translation for page `fill_vpn` (tag `fill_vpn[19:5]`, set `fill_vpn[4:0]`) with page number `fill_ppn` and write permission `fill_wr_ok`. The translation starts clean, and a lookup sees it from the next cycle onwards.
- R6: Each set keeps a full recency order of its four ways. A refill replaces the least recent way. A non-faulting hit or a refill makes the way it used the most recent. After reset or invalidation, refills of a set take ways 0, 1, 2 and 3 in turn.
- R7: One cycle after a refill whose victim was valid and dirty, `evict_valid` is 1 for that cycle. At the same time `evict_tag`, `evict_set`, `evict_ppn` and `evict_ref` carry the victim's fields. After any other cycle `evict_valid` is 0.
- R8: `inval_all` clears every valid flag and restores the initial recency order in one cycle. A refill or lookup update arriving in the same cycle is discarded, and all lookups miss from the next cycle.
- R9: When a non-faulting hit and a refill address the same set in one cycle, the hit is applied to the recency order first. The refill therefore never replaces the way just hit, and it becomes the most recent way itself.
- R10: After reset the buffer is empty, every lookup misses and `evict_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inval_all | input | 1 | Empty the whole buffer this cycle |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Request is a write |
| lk_hit | output | 1 | Translation found |
| lk_miss | output | 1 | Translation absent |
| lk_fault | output | 1 | Write to a translation without write permission |
| lk_paddr | output | 30 | Physical address |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number being installed |
| fill_ppn | input | 18 | Physical page number being installed |
| fill_wr_ok | input | 1 | Write permission of the new translation |
| evict_valid | output | 1 | A dirty translation was displaced |
| evict_tag | output | 15 | Tag of the displaced translation |
| evict_set | output | 5 | Set of the displaced translation |
| evict_ppn | output | 18 | Page number of the displaced translation |
| evict_ref | output | 1 | Reference flag of the displaced translation |

## Verification
A lookup hit and a refill can fall in the same cycle and in the same set. Both then change that set's recency order. The bench fills all four ways of one set so that way 0 is oldest. In a single cycle it presents a read hit on way 0 together with a refill of a new page. The result is judged through later lookups: the way-0 page and the new page must both hit, and the page from way 1, now the oldest, must miss. A second overlap, invalidation arriving together with a refill, is checked the same way, by finding the refilled page absent afterwards.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W  = 32;
    localparam int PA_W  = 30;
    localparam int OFF_W = 12;
    localparam int SETS  = 32;
    localparam int WAYS  = 4;

    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VA_W - OFF_W - IDX_W;
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [PPN_W-1:0] ppn_t;
    typedef logic [WAY_W-1:0] way_t;
    typedef logic [WAY_W-1:0] age_t;
    typedef age_t [WAYS-1:0]  age_vec_t;

    // One stored translation
    typedef struct packed {
        logic valid;
        logic dirty;
        logic refd;
        logic wr_ok;
        tag_t tag;
        ppn_t ppn;
    } entry_t;

    // What a lookup needs from the matching way
    typedef struct packed {
        logic wr_ok;
        ppn_t ppn;
    } hit_info_t;

    // What a refill needs from the displaced way
    typedef struct packed {
        logic dirty;   // valid and dirty
        logic refd;
        tag_t tag;
        ppn_t ppn;
    } victim_t;

    function automatic idx_t va_idx(logic [VA_W-1:0] va);
        return va[OFF_W +: IDX_W];
    endfunction

    function automatic tag_t va_tag(logic [VA_W-1:0] va);
        return va[OFF_W+IDX_W +: TAG_W];
    endfunction

    // Age 0 is most recent, WAYS-1 is the replacement candidate.
    function automatic age_vec_t age_init();
        age_vec_t r;
        for (int i = 0; i < WAYS; i++) r[i] = age_t'(WAYS - 1 - i);
        return r;
    endfunction

    function automatic age_vec_t age_touch(age_vec_t a, way_t w);
        age_vec_t r;
        for (int i = 0; i < WAYS; i++) begin
            if (way_t'(i) == w)   r[i] = '0;
            else if (a[i] < a[w]) r[i] = a[i] + age_t'(1);
            else                  r[i] = a[i];
        end
        return r;
    endfunction

    function automatic way_t age_oldest(age_vec_t a);
        way_t r = '0;
        for (int i = 0; i < WAYS; i++)
            if (a[i] == age_t'(WAYS - 1)) r = way_t'(i);
        return r;
    endfunction

    function automatic way_t onehot_to_way(logic [WAYS-1:0] v);
        way_t r = '0;
        for (int i = 0; i < WAYS; i++)
            if (v[i]) r = way_t'(i);
        return r;
    endfunction

endpackage

// File: rtl/xlat_way.sv
module xlat_way
    import xlat_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  idx_t      lk_idx,
    input  tag_t      lk_tag,
    output logic      lk_match,
    output hit_info_t lk_info,
    input  logic      upd_en,
    input  logic      upd_dirty,
    input  idx_t      fill_idx,
    input  logic      fill_en,
    input  entry_t    fill_ent,
    output victim_t   fill_old
);

    entry_t store [SETS];
    entry_t lk_ent;
    entry_t old_ent;

    always_comb begin
        lk_ent        = store[lk_idx];
        lk_match      = lk_ent.valid && (lk_ent.tag == lk_tag);
        lk_info.wr_ok = lk_ent.wr_ok;
        lk_info.ppn   = lk_ent.ppn;
    end

    always_comb begin
        old_ent        = store[fill_idx];
        fill_old.dirty = old_ent.valid && old_ent.dirty;
        fill_old.refd  = old_ent.refd;
        fill_old.tag   = old_ent.tag;
        fill_old.ppn   = old_ent.ppn;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) store[s] <= '0;
        end else if (clr) begin
            for (int s = 0; s < SETS; s++) store[s].valid <= 1'b0;
        end else begin
            if (upd_en) begin
                store[lk_idx].refd <= 1'b1;
                if (upd_dirty) store[lk_idx].dirty <= 1'b1;
            end
            // A refill never targets the way a same-set hit used.
            if (fill_en) store[fill_idx] <= fill_ent;
        end
    end

endmodule

// File: rtl/xlat_lru.sv
module xlat_lru
    import xlat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  idx_t lk_idx,
    input  logic lk_touch,
    input  way_t lk_way,
    input  idx_t fill_idx,
    input  logic fill_en,
    output way_t victim
);

    age_vec_t ages [SETS];
    age_vec_t fill_view;

    // The refill sees the order after a same-cycle hit in its set.
    always_comb begin
        fill_view = ages[fill_idx];
        if (lk_touch && (lk_idx == fill_idx))
            fill_view = age_touch(fill_view, lk_way);
    end

    assign victim = age_oldest(fill_view);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int s = 0; s < SETS; s++) ages[s] <= age_init();
        end else begin
            if (lk_touch) ages[lk_idx] <= age_touch(ages[lk_idx], lk_way);
            if (fill_en)  ages[fill_idx] <= age_touch(fill_view, victim);
        end
    end

endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
    import xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inval_all,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic              fill_valid,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic              fill_wr_ok,
    output logic              evict_valid,
    output logic [TAG_W-1:0]  evict_tag,
    output logic [IDX_W-1:0]  evict_set,
    output logic [PPN_W-1:0]  evict_ppn,
    output logic              evict_ref
);

    idx_t            lk_idx;
    tag_t            lk_tag;
    idx_t            fill_idx;
    logic [WAYS-1:0] way_match;
    hit_info_t       way_info [WAYS];
    victim_t         way_old  [WAYS];
    way_t            hit_way;
    way_t            victim;
    hit_info_t       hit_info;
    victim_t         old_sel;
    logic            any_match;
    logic            do_upd;
    logic            do_fill;
    entry_t          new_ent;

    assign lk_idx   = va_idx(lk_vaddr);
    assign lk_tag   = va_tag(lk_vaddr);
    assign fill_idx = fill_vpn[IDX_W-1:0];

    always_comb begin
        new_ent       = '0;
        new_ent.valid = 1'b1;
        new_ent.wr_ok = fill_wr_ok;
        new_ent.tag   = fill_vpn[VPN_W-1:IDX_W];
        new_ent.ppn   = fill_ppn;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        xlat_way u_way (
            .clk       (clk),
            .rst       (rst),
            .clr       (inval_all),
            .lk_idx    (lk_idx),
            .lk_tag    (lk_tag),
            .lk_match  (way_match[w]),
            .lk_info   (way_info[w]),
            .upd_en    (do_upd && (hit_way == way_t'(w))),
            .upd_dirty (lk_write),
            .fill_idx  (fill_idx),
            .fill_en   (do_fill && (victim == way_t'(w))),
            .fill_ent  (new_ent),
            .fill_old  (way_old[w])
        );
    end

    // Parallel compare, then a WAYS-to-1 selection of the matching way
    always_comb begin
        any_match = |way_match;
        hit_way   = onehot_to_way(way_match);
        hit_info  = way_info[hit_way];
        old_sel   = way_old[victim];
    end

    always_comb begin
        lk_hit   = lk_valid && any_match;
        lk_miss  = lk_valid && !any_match;
        lk_fault = lk_hit && lk_write && !hit_info.wr_ok;
        lk_paddr = lk_hit ? {hit_info.ppn, lk_vaddr[OFF_W-1:0]} : '0;
        do_upd   = lk_hit && !lk_fault && !inval_all;
        do_fill  = fill_valid && !inval_all;
    end

    xlat_lru u_lru (
        .clk      (clk),
        .rst      (rst),
        .clr      (inval_all),
        .lk_idx   (lk_idx),
        .lk_touch (do_upd),
        .lk_way   (hit_way),
        .fill_idx (fill_idx),
        .fill_en  (do_fill),
        .victim   (victim)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            evict_valid <= 1'b0;
            evict_tag   <= '0;
            evict_set   <= '0;
            evict_ppn   <= '0;
            evict_ref   <= 1'b0;
        end else begin
            evict_valid <= do_fill && old_sel.dirty;
            if (do_fill) begin
                evict_tag <= old_sel.tag;
                evict_set <= fill_idx;
                evict_ppn <= old_sel.ppn;
                evict_ref <= old_sel.refd;
            end
        end
    end

endmodule

// File: rtl/xlat_buf_chk.sv
module xlat_buf_chk
    import xlat_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              inval_all,
    input logic              lk_valid,
    input logic [VA_W-1:0]   lk_vaddr,
    input logic              lk_write,
    input logic              lk_hit,
    input logic              lk_miss,
    input logic              lk_fault,
    input logic [PA_W-1:0]   lk_paddr,
    input logic              fill_valid,
    input logic [VPN_W-1:0]  fill_vpn,
    input logic [PPN_W-1:0]  fill_ppn,
    input logic              fill_wr_ok,
    input logic              evict_valid,
    input logic [TAG_W-1:0]  evict_tag,
    input logic [IDX_W-1:0]  evict_set,
    input logic [PPN_W-1:0]  evict_ppn,
    input logic              evict_ref
);

    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    assert_hit_xor_miss_R2: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> (lk_hit != lk_miss));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |-> !(lk_hit || lk_miss || lk_fault));

    assert_fault_on_write_hit_R3: assert property (@(posedge clk) disable iff (rst)
        lk_fault |-> (lk_hit && lk_write));

    assert_evict_follows_fill_R7: assert property (@(posedge clk) disable iff (rst)
        evict_valid |-> $past(fill_valid && !inval_all));

    assert_inval_empties_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(inval_all) && lk_valid) |-> !lk_hit);

endmodule

bind xlat_buf xlat_buf_chk u_chk (.*);

// File: tb/xlat_buf_tb.sv
module xlat_buf_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        inval_all = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic        lk_write = 1'b0;
    logic        lk_hit, lk_miss, lk_fault;
    logic [29:0] lk_paddr;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [17:0] fill_ppn = '0;
    logic        fill_wr_ok = 1'b0;
    logic        evict_valid;
    logic [14:0] evict_tag;
    logic [4:0]  evict_set;
    logic [17:0] evict_ppn;
    logic        evict_ref;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    xlat_buf u_dut (.*);

    // captured results
    logic        r_hit, r_miss, r_fault;
    logic [29:0] r_pa;
    logic        e_valid, e_ref;
    logic [14:0] e_tag;
    logic [4:0]  e_set;
    logic [17:0] e_ppn;

    typedef struct packed {
        logic        is_fill;
        logic [31:0] va;
        logic        wr;
        logic [17:0] ppn;
        logic        wok;
        logic        ehit;
        logic        efault;
        logic [29:0] epa;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VT [NV] = '{
        '{1'b0, 32'h0002_3123, 1'b0, 18'h0,     1'b0, 1'b0, 1'b0, 30'h0},
        '{1'b1, 32'h0002_3000, 1'b0, 18'h2ABCD, 1'b1, 1'b0, 1'b0, 30'h0},
        '{1'b0, 32'h0002_3123, 1'b0, 18'h0,     1'b0, 1'b1, 1'b0, 30'h2ABCD123},
        '{1'b0, 32'h0004_3123, 1'b0, 18'h0,     1'b0, 1'b0, 1'b0, 30'h0},
        '{1'b0, 32'h0002_4123, 1'b0, 18'h0,     1'b0, 1'b0, 1'b0, 30'h0},
        '{1'b1, 32'hFFFF_F000, 1'b0, 18'h3FFFF, 1'b0, 1'b0, 1'b0, 30'h0},
        '{1'b0, 32'hFFFF_FFFF, 1'b0, 18'h0,     1'b0, 1'b1, 1'b0, 30'h3FFFFFFF},
        '{1'b0, 32'hFFFF_FFFF, 1'b1, 18'h0,     1'b0, 1'b1, 1'b1, 30'h3FFFFFFF},
        '{1'b0, 32'h0002_3123, 1'b1, 18'h0,     1'b0, 1'b1, 1'b0, 30'h2ABCD123}
    };

    function automatic logic [31:0] mkva(int tag, int set, int off);
        return {tag[14:0], set[4:0], off[11:0]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic look(logic [31:0] va, logic wr);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_write = wr;
        #1;
        r_hit = lk_hit; r_miss = lk_miss; r_fault = lk_fault; r_pa = lk_paddr;
        @(posedge clk); #1;
        lk_valid = 1'b0; lk_write = 1'b0;
    endtask

    task automatic grab_evict();
        e_valid = evict_valid; e_tag = evict_tag; e_set = evict_set;
        e_ppn = evict_ppn; e_ref = evict_ref;
    endtask

    task automatic fill(int tag, int set, logic [17:0] ppn, logic wok);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = {tag[14:0], set[4:0]};
        fill_ppn = ppn; fill_wr_ok = wok;
        @(posedge clk); #1;
        grab_evict();
        fill_valid = 1'b0;
    endtask

    // lookup hit and refill presented together
    task automatic look_and_fill(logic [31:0] va, int tag, int set, logic [17:0] ppn);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_write = 1'b0;
        fill_valid = 1'b1; fill_vpn = {tag[14:0], set[4:0]};
        fill_ppn = ppn; fill_wr_ok = 1'b1;
        #1;
        r_hit = lk_hit; r_miss = lk_miss; r_fault = lk_fault; r_pa = lk_paddr;
        @(posedge clk); #1;
        grab_evict();
        lk_valid = 1'b0; fill_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        #1;
        chk("R10 evict_valid after reset", 32'(evict_valid), 32'd0);
        chk("R2 idle hit/miss/fault", {29'd0, lk_hit, lk_miss, lk_fault}, 32'd0);
        look(mkva(0, 0, 0), 1'b0);
        chk("R10 empty lookup misses", {30'd0, r_hit, r_miss}, 32'd1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            if (VT[i].is_fill) begin
                fill(int'(VT[i].va[31:17]), int'(VT[i].va[16:12]), VT[i].ppn, VT[i].wok);
                chk("R7 no evict on empty way", 32'(e_valid), 32'd0);
            end else begin
                look(VT[i].va, VT[i].wr);
                chk("R2 hit", 32'(r_hit), 32'(VT[i].ehit));
                chk("R2 miss", 32'(r_miss), 32'(!VT[i].ehit));
                chk("R3 R5 fault", 32'(r_fault), 32'(VT[i].efault));
                chk("R1 paddr", 32'(r_pa), 32'(VT[i].epa));
            end
        end

        // R6 R7 R4: set 3 holds page A (tag 1) in way 0, dirty after write hit
        fill(3, 3, 18'h00003, 1'b1);
        fill(4, 3, 18'h00004, 1'b1);
        fill(5, 3, 18'h00005, 1'b1);
        chk("R6 fills take free ways in order", 32'(e_valid), 32'd0);
        fill(6, 3, 18'h00006, 1'b1);
        chk("R7 R4 dirty victim reported", 32'(e_valid), 32'd1);
        chk("R7 evict tag", 32'(e_tag), 32'd1);
        chk("R7 evict set", 32'(e_set), 32'd3);
        chk("R7 evict ppn", 32'(e_ppn), 32'h2ABCD);
        chk("R4 reference flag", 32'(e_ref), 32'd1);
        #4;
        chk("R7 evict is one pulse", 32'(evict_valid), 32'd0);
        look(mkva(1, 3, 0), 1'b0);
        chk("R6 oldest page replaced", 32'(r_miss), 32'd1);

        // R6 hit moves tag 3 to most recent; tag 4 becomes victim
        look(mkva(3, 3, 0), 1'b0);
        chk("R6 hit before reorder", 32'(r_hit), 32'd1);
        fill(7, 3, 18'h00007, 1'b1);
        chk("R6 clean victim not reported", 32'(e_valid), 32'd0);
        look(mkva(4, 3, 0), 1'b0);
        chk("R6 least recent page gone", 32'(r_miss), 32'd1);
        look(mkva(3, 3, 0), 1'b0);
        chk("R6 touched page kept", 32'(r_hit), 32'd1);

        // R3: faulted write left set-31 page clean
        fill(16, 31, 18'h00010, 1'b1);
        fill(17, 31, 18'h00011, 1'b1);
        fill(18, 31, 18'h00012, 1'b1);
        fill(19, 31, 18'h00013, 1'b1);
        chk("R3 faulted page stayed clean", 32'(e_valid), 32'd0);
        look(32'hFFFF_FFFF, 1'b0);
        chk("R3 faulted page evicted", 32'(r_miss), 32'd1);

        // R3: fault does not refresh recency
        fill(32, 5, 18'h00020, 1'b0);
        fill(33, 5, 18'h00021, 1'b1);
        fill(34, 5, 18'h00022, 1'b1);
        fill(35, 5, 18'h00023, 1'b1);
        look(mkva(32, 5, 0), 1'b1);
        chk("R3 write fault raised", 32'(r_fault), 32'd1);
        fill(36, 5, 18'h00024, 1'b1);
        look(mkva(32, 5, 0), 1'b0);
        chk("R3 faulted page still oldest", 32'(r_miss), 32'd1);
        look(mkva(33, 5, 0), 1'b0);
        chk("R3 next page kept", 32'(r_hit), 32'd1);

        // R9: same-set hit and refill in one cycle
        fill(48, 9, 18'h00030, 1'b1);
        fill(49, 9, 18'h00031, 1'b1);
        fill(50, 9, 18'h00032, 1'b1);
        fill(51, 9, 18'h00033, 1'b1);
        look_and_fill(mkva(48, 9, 7), 52, 9, 18'h00034);
        chk("R9 concurrent lookup hits", 32'(r_hit), 32'd1);
        chk("R9 concurrent paddr", 32'(r_pa), 32'h00030007);
        look(mkva(48, 9, 0), 1'b0);
        chk("R9 hit way not replaced", 32'(r_hit), 32'd1);
        look(mkva(49, 9, 0), 1'b0);
        chk("R9 next oldest replaced", 32'(r_miss), 32'd1);
        look(mkva(52, 9, 0), 1'b0);
        chk("R9 refilled page present", 32'(r_hit), 32'd1);

        // R8: invalidate together with a refill
        @(negedge clk);
        inval_all = 1'b1;
        fill_valid = 1'b1; fill_vpn = {15'd60, 5'd7}; fill_ppn = 18'h00040; fill_wr_ok = 1'b1;
        @(posedge clk); #1;
        inval_all = 1'b0; fill_valid = 1'b0;
        chk("R8 no eviction on discarded refill", 32'(evict_valid), 32'd0);
        look(mkva(3, 3, 0), 1'b0);
        chk("R8 entries invalidated", 32'(r_miss), 32'd1);
        look(mkva(60, 7, 0), 1'b0);
        chk("R8 same-cycle refill discarded", 32'(r_miss), 32'd1);
        look(mkva(52, 9, 0), 1'b0);
        chk("R8 other set invalidated", 32'(r_miss), 32'd1);

        // R8 R6: order restored, first refill uses way 0 and is oldest
        fill(70, 3, 18'h00050, 1'b1);
        look(mkva(70, 3, 0), 1'b1);
        chk("R5 new entry visible", 32'(r_hit), 32'd1);
        fill(71, 3, 18'h00051, 1'b1);
        fill(72, 3, 18'h00052, 1'b1);
        fill(73, 3, 18'h00053, 1'b1);
        chk("R8 stale dirty flags ignored", 32'(e_valid), 32'd0);
        fill(74, 3, 18'h00054, 1'b1);
        chk("R8 R4 evicts written page", 32'(e_valid), 32'd1);
        chk("R8 evicted tag", 32'(e_tag), 32'd70);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule